// File: doc/BRIEF.md
# Ping-Pong Layer Configuration Controller

This block is the register front end for one processing engine in an accelerator that runs a network layer by layer. A host fills in the settings of one hardware layer through a simple register-write port and then writes an activate command. The block holds two groups of configuration registers that take turns. While the engine runs the layer held in one group, the host can fill in the other group and activate it. That queued layer goes to the engine as soon as the running layer completes, and the host does nothing further to start it.

Two one-bit pointers track the two groups. The producer pointer selects which group host writes reach. It flips on every accepted activate. The consumer pointer selects which group drives the engine. It flips on every accepted completion. The engine itself is outside the block. It sees a one-cycle start pulse together with the selected group's settings, and it answers with a one-cycle done pulse. Each finished layer sets a sticky completion flag for its group. The host clears that flag by writing 1 to it. The interrupt line is the OR of every flag that is not masked.

The register window holds NREG configuration words at addresses 0 to NREG-1, then the control word (NREG), the status word (NREG+1), the completion flags (NREG+2) and the interrupt mask (NREG+3). The control, status, flag and mask addresses are fixed by this layout.

Top module: `layer_cfg_dbuf`

## Requirements
- R1: After reset, both group enables, both pointers, the error bit, the completion flags and the mask are 0. The irq and eng_start outputs are low, and the status and flag words read as 0.
- R2: A write to address a < NREG stores wr_data in word a of the group the producer pointer selects. When rd_en is high, rd_data shows the addressed word of that group from the next clock edge onward.
- R3: Writing a word with bit 0 set to address NREG activates the producer group when that group is not enabled. Its enable bit sets and the producer pointer flips. In the status word at NREG+1, bit 0 is enable 0, bit 1 is enable 1, bit 2 is the producer pointer, bit 3 is the consumer pointer and bit 4 is the error bit.
- R4: In any cycle where no layer is running and the consumer group is enabled, eng_start is high for exactly one cycle. In that cycle eng_cfg carries the consumer group's words, with word k at bits [k*DW +: DW]. A start follows in the cycle after the activating write.
- R5: A done pulse while a layer is running clears the consumer group's enable, flips the consumer pointer and sets that group's completion flag. The flag for group g is bit g of the word at NREG+2.
- R6: When the other group is already enabled as the running layer completes, its start pulse comes in the cycle right after the done pulse, with no host write in between.
- R7: A configuration write or an activate aimed at an enabled group is ignored: stored words, enables and pointers stay as they were. It sets the sticky error bit instead. Writing 1 to bit 4 at NREG+1 clears that bit, and a new error in the same cycle takes priority over the clear.
- R8: Writing 1 to bit g at NREG+2 clears completion flag g. Writing 0 leaves the flag unchanged. A completion in the same cycle takes priority over the clear.
- R9: irq is high exactly when some completion flag is set and its bit in the mask word at NREG+3 is 0.
- R10: A done pulse while no layer is running has no effect on enables, pointers, flags or irq.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register write address |
| wr_data | input | DW | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | AW | Register read address |
| rd_data | output | DW | Registered read data |
| eng_start | output | 1 | One-cycle layer start pulse to the engine |
| eng_cfg | output | NREG*DW | Consumer group settings for the engine |
| eng_done | input | 1 | One-cycle layer completion pulse from the engine |
| irq | output | 1 | Completion interrupt |

## Verification
Every result shows up a fixed number of edges after the stimulus that causes it. Register state and the irq level change at the edge that samples a write or a done pulse. Read data appears at the edge that samples rd_en. eng_start rises in the cycle after an activate or a done edge and is gone one edge later. The bench drives every input on a falling edge and lets exactly one rising edge pass. It then compares the outputs at the next falling edge with values from a requirement-level model. That model is stepped once per edge, so each comparison lines up with the cycle in which the result is due.

// File: rtl/lcfg_pkg.sv
`timescale 1ns/1ps
package lcfg_pkg;
  localparam int NGRP = 2;

  typedef enum logic [2:0] {
    AK_CFG  = 3'd0,
    AK_CTRL = 3'd1,
    AK_STAT = 3'd2,
    AK_IRQ  = 3'd3,
    AK_MASK = 3'd4,
    AK_NONE = 3'd5
  } addr_kind_e;

  localparam int CTRL_GO  = 0;
  localparam int ST_ERR   = 4;
  localparam int ST_WIDTH = 5;
endpackage

// File: rtl/lcfg_addr_dec.sv
`timescale 1ns/1ps
module lcfg_addr_dec #(
  parameter int NREG = 4,
  parameter int AW   = 4,
  parameter int IDXW = 2
) (
  input  logic [AW-1:0]           addr,
  output lcfg_pkg::addr_kind_e    kind,
  output logic [IDXW-1:0]         idx
);
  import lcfg_pkg::*;

  localparam logic [AW-1:0] A_CTRL = AW'(NREG);
  localparam logic [AW-1:0] A_STAT = AW'(NREG + 1);
  localparam logic [AW-1:0] A_IRQ  = AW'(NREG + 2);
  localparam logic [AW-1:0] A_MASK = AW'(NREG + 3);

  always_comb begin
    idx = addr[IDXW-1:0];
    if (addr < A_CTRL)       kind = AK_CFG;
    else if (addr == A_CTRL) kind = AK_CTRL;
    else if (addr == A_STAT) kind = AK_STAT;
    else if (addr == A_IRQ)  kind = AK_IRQ;
    else if (addr == A_MASK) kind = AK_MASK;
    else                     kind = AK_NONE;
  end
endmodule

// File: rtl/lcfg_regbank.sv
`timescale 1ns/1ps
module lcfg_regbank #(
  parameter int NREG = 4,
  parameter int DW   = 32,
  parameter int IDXW = 2
) (
  input  logic                 clk,
  input  logic                 wr_en,
  input  logic                 wr_grp,
  input  logic [IDXW-1:0]      wr_idx,
  input  logic [DW-1:0]        wr_data,
  input  logic                 rd_grp,
  input  logic [IDXW-1:0]      rd_idx,
  output logic [DW-1:0]        rd_val,
  input  logic                 eng_grp,
  output logic [NREG*DW-1:0]   eng_cfg
);
  import lcfg_pkg::*;

  logic [NGRP-1:0][NREG-1:0][DW-1:0] bank;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    for (genvar r = 0; r < NREG; r++) begin : g_word
      logic          hit;
      logic [DW-1:0] word_q;

      assign hit = wr_en && (wr_grp == 1'(g)) && (wr_idx == IDXW'(r));

      always_ff @(posedge clk) begin
        if (hit) word_q <= wr_data;
      end

      assign bank[g][r] = word_q;
    end
  end

  assign rd_val  = bank[rd_grp][rd_idx];
  assign eng_cfg = bank[eng_grp];
endmodule

// File: rtl/lcfg_seq.sv
`timescale 1ns/1ps
module lcfg_seq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       act_req,
  input  logic       done_in,
  output logic       prod_ptr,
  output logic       cons_ptr,
  output logic [1:0] en_vec,
  output logic       busy,
  output logic       start,
  output logic [1:0] done_vec
);
  logic       prod_q, prod_n;
  logic       cons_q, cons_n;
  logic [1:0] en_q, en_n;
  logic       busy_q, busy_n;
  logic       act_acc, done_acc;
  logic       en_upd, busy_upd;

  always_comb begin
    start    = !busy_q && en_q[cons_q];
    act_acc  = act_req && !en_q[prod_q];
    done_acc = done_in && busy_q;

    en_n = en_q;
    if (act_acc)  en_n[prod_q] = 1'b1;
    if (done_acc) en_n[cons_q] = 1'b0;
    en_upd = act_acc || done_acc;

    prod_n = ~prod_q;
    cons_n = ~cons_q;

    busy_n   = start;
    busy_upd = start || done_acc;

    done_vec = 2'b00;
    if (done_acc) done_vec[cons_q] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_q <= 1'b0;
      cons_q <= 1'b0;
      en_q   <= 2'b00;
      busy_q <= 1'b0;
    end else begin
      if (act_acc)  prod_q <= prod_n;
      if (done_acc) cons_q <= cons_n;
      if (en_upd)   en_q   <= en_n;
      if (busy_upd) busy_q <= busy_n;
    end
  end

  assign prod_ptr = prod_q;
  assign cons_ptr = cons_q;
  assign en_vec   = en_q;
  assign busy     = busy_q;
endmodule

// File: rtl/lcfg_irq.sv
`timescale 1ns/1ps
module lcfg_irq #(
  parameter int NG = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NG-1:0] set_vec,
  input  logic [NG-1:0] clr_vec,
  input  logic          mask_we,
  input  logic [NG-1:0] mask_wd,
  output logic [NG-1:0] sts,
  output logic [NG-1:0] mask,
  output logic          irq
);
  logic [NG-1:0] sts_q, sts_n;
  logic [NG-1:0] mask_q;
  logic          sts_upd;

  always_comb begin
    sts_n   = (sts_q & ~clr_vec) | set_vec;
    sts_upd = |set_vec || |clr_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q  <= '0;
      mask_q <= '0;
    end else begin
      if (sts_upd) sts_q  <= sts_n;
      if (mask_we) mask_q <= mask_wd;
    end
  end

  assign sts  = sts_q;
  assign mask = mask_q;
  assign irq  = |(sts_q & ~mask_q);
endmodule

// File: rtl/layer_cfg_dbuf.sv
`timescale 1ns/1ps
module layer_cfg_dbuf #(
  parameter int DW   = 32,
  parameter int NREG = 4,
  parameter int AW   = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [AW-1:0]       wr_addr,
  input  logic [DW-1:0]       wr_data,
  input  logic                rd_en,
  input  logic [AW-1:0]       rd_addr,
  output logic [DW-1:0]       rd_data,
  output logic                eng_start,
  output logic [NREG*DW-1:0]  eng_cfg,
  input  logic                eng_done,
  output logic                irq
);
  import lcfg_pkg::*;

  localparam int IDXW = (NREG > 1) ? $clog2(NREG) : 1;

  addr_kind_e           wr_kind, rd_kind;
  logic [IDXW-1:0]      wr_idx, rd_idx;
  logic                 prod_ptr, cons_ptr, busy;
  logic [1:0]           en_vec, done_vec, irq_sts, irq_mask;
  logic                 cfg_wr, act_req, cfg_we;
  logic                 err_q, err_n, err_set, err_clr, err_upd;
  logic [1:0]           sts_clr;
  logic                 mask_we;
  logic [DW-1:0]        bank_rd, rd_nxt;
  logic [ST_WIDTH-1:0]  stat_word;

  lcfg_addr_dec #(.NREG(NREG), .AW(AW), .IDXW(IDXW)) u_wdec (
    .addr(wr_addr), .kind(wr_kind), .idx(wr_idx)
  );

  lcfg_addr_dec #(.NREG(NREG), .AW(AW), .IDXW(IDXW)) u_rdec (
    .addr(rd_addr), .kind(rd_kind), .idx(rd_idx)
  );

  always_comb begin
    cfg_wr  = wr_en && (wr_kind == AK_CFG);
    act_req = wr_en && (wr_kind == AK_CTRL) && wr_data[CTRL_GO];
    cfg_we  = cfg_wr && !en_vec[prod_ptr];
    err_set = (cfg_wr || act_req) && en_vec[prod_ptr];
    err_clr = wr_en && (wr_kind == AK_STAT) && wr_data[ST_ERR];
    err_n   = (err_q && !err_clr) || err_set;
    err_upd = err_set || err_clr;
    sts_clr = (wr_en && (wr_kind == AK_IRQ)) ? wr_data[1:0] : 2'b00;
    mask_we = wr_en && (wr_kind == AK_MASK);
  end

  lcfg_regbank #(.NREG(NREG), .DW(DW), .IDXW(IDXW)) u_bank (
    .clk(clk), .wr_en(cfg_we), .wr_grp(prod_ptr), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_grp(prod_ptr), .rd_idx(rd_idx), .rd_val(bank_rd),
    .eng_grp(cons_ptr), .eng_cfg(eng_cfg)
  );

  lcfg_seq u_seq (
    .clk(clk), .rst_n(rst_n), .act_req(act_req), .done_in(eng_done),
    .prod_ptr(prod_ptr), .cons_ptr(cons_ptr), .en_vec(en_vec),
    .busy(busy), .start(eng_start), .done_vec(done_vec)
  );

  lcfg_irq #(.NG(NGRP)) u_irq (
    .clk(clk), .rst_n(rst_n), .set_vec(done_vec), .clr_vec(sts_clr),
    .mask_we(mask_we), .mask_wd(wr_data[1:0]), .sts(irq_sts),
    .mask(irq_mask), .irq(irq)
  );

  assign stat_word = {err_q, cons_ptr, prod_ptr, en_vec};

  always_comb begin
    unique case (rd_kind)
      AK_CFG:  rd_nxt = bank_rd;
      AK_STAT: rd_nxt = DW'(stat_word);
      AK_IRQ:  rd_nxt = DW'(irq_sts);
      AK_MASK: rd_nxt = DW'(irq_mask);
      default: rd_nxt = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q   <= 1'b0;
      rd_data <= '0;
    end else begin
      if (err_upd) err_q   <= err_n;
      if (rd_en)   rd_data <= rd_nxt;
    end
  end
endmodule

// File: rtl/lcfg_chk.sv
`timescale 1ns/1ps
module lcfg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       eng_start,
  input logic       eng_done,
  input logic       busy,
  input logic       prod_ptr,
  input logic       cons_ptr,
  input logic [1:0] en_vec,
  input logic [1:0] irq_sts,
  input logic       err_q,
  input logic       err_clr,
  input logic       irq
);
  // R4: start never lasts longer than one cycle
  p_start_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start);

  // R5: an accepted completion sets the flag of the group that finished
  p_done_flag0_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done && busy && !cons_ptr) |=> irq_sts[0]);
  p_done_flag1_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done && busy && cons_ptr) |=> irq_sts[1]);

  // R6: a queued group starts right after the running one completes
  p_back_to_back_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done && busy && en_vec[~cons_ptr]) |=> eng_start);

  // R10: completion while idle leaves the consumer pointer alone
  p_idle_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done && !busy) |=> $stable(cons_ptr));

  // R7: error bit only drops after a host clear
  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err_q) |-> $past(err_clr));

  // R3: group 0 is only enabled while the producer points at it
  p_act_grp0_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_vec[0]) |-> ($past(prod_ptr) == 1'b0) && prod_ptr);

  // R9: no flag, no interrupt
  p_irq_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_sts == 2'b00) |-> !irq);
endmodule

bind layer_cfg_dbuf lcfg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .eng_start(eng_start), .eng_done(eng_done),
  .busy(busy), .prod_ptr(prod_ptr), .cons_ptr(cons_ptr), .en_vec(en_vec),
  .irq_sts(irq_sts), .err_q(err_q), .err_clr(err_clr), .irq(irq)
);

// File: tb/test_layer_cfg_dbuf.sv
`timescale 1ns/1ps
module test_layer_cfg_dbuf;
  localparam int DW = 32;
  localparam int NREG = 4;
  localparam int AW = 4;

  logic               clk;
  logic               rst_n;
  logic               wr_en;
  logic [AW-1:0]      wr_addr;
  logic [DW-1:0]      wr_data;
  logic               rd_en;
  logic [AW-1:0]      rd_addr;
  logic [DW-1:0]      rd_data;
  logic               eng_start;
  logic [NREG*DW-1:0] eng_cfg;
  logic               eng_done;
  logic               irq;

  layer_cfg_dbuf #(.DW(DW), .NREG(NREG), .AW(AW)) i_layer_cfg_dbuf (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .eng_start(eng_start), .eng_cfg(eng_cfg), .eng_done(eng_done), .irq(irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int  checks = 0;
  int  errors = 0;
  bit  finished = 0;

  // requirement-level model
  bit          m_prod, m_cons, m_busy, m_err, m_after_done;
  bit [1:0]    m_en, m_sts, m_mask;
  logic [DW-1:0] m_cfg [2][NREG];

  task automatic chk(string tag, logic [NREG*DW-1:0] act, logic [NREG*DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(int l, int k);
    return DW'((l << 24) | (k << 16) | ((l * 37 + k * 11) & 16'hFFFF));
  endfunction

  task automatic step(bit w, int wa, logic [DW-1:0] wd, bit r, int ra, bit dn, string rtag);
    logic [DW-1:0] exp_rd;
    bit start_now, done_ok, eset, eclr, exp_start;
    bit [1:0] sset, sclr;
    logic [NREG*DW-1:0] exp_cfg;
    if (ra < NREG)           exp_rd = m_cfg[m_prod][ra];
    else if (ra == NREG + 1) exp_rd = DW'({m_err, m_cons, m_prod, m_en});
    else if (ra == NREG + 2) exp_rd = DW'(m_sts);
    else if (ra == NREG + 3) exp_rd = DW'(m_mask);
    else                     exp_rd = '0;
    wr_en = w; wr_addr = AW'(wa); wr_data = wd;
    rd_en = r; rd_addr = AW'(ra); eng_done = dn;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0; eng_done = 1'b0;
    start_now = !m_busy && m_en[m_cons];
    done_ok = dn && m_busy;
    eset = 0; eclr = 0; sset = 0; sclr = 0;
    if (w) begin
      if (wa < NREG) begin
        if (m_en[m_prod]) eset = 1; else m_cfg[m_prod][wa] = wd;
      end else if (wa == NREG && wd[0]) begin
        if (m_en[m_prod]) eset = 1;
        else begin m_en[m_prod] = 1; m_prod = ~m_prod; end
      end else if (wa == NREG + 1) eclr = wd[4];
      else if (wa == NREG + 2) sclr = wd[1:0];
      else if (wa == NREG + 3) m_mask = wd[1:0];
    end
    if (done_ok) begin
      m_en[m_cons] = 0; sset[m_cons] = 1; m_cons = ~m_cons;
    end
    if (start_now) m_busy = 1; else if (done_ok) m_busy = 0;
    m_sts = (m_sts & ~sclr) | sset;
    m_err = (m_err & ~eclr) | eset;
    m_after_done = done_ok;
    if (r) chk(rtag, NREG*DW'(rd_data), NREG*DW'(exp_rd));
    exp_start = !m_busy && m_en[m_cons];
    chk(m_after_done ? "R6" : "R4", NREG*DW'(eng_start), NREG*DW'(exp_start));
    if (exp_start) begin
      for (int k = 0; k < NREG; k++) exp_cfg[k*DW +: DW] = m_cfg[m_cons][k];
      chk("R4", eng_cfg, exp_cfg);
    end
    chk("R9", NREG*DW'(irq), NREG*DW'(|(m_sts & ~m_mask)));
  endtask

  task automatic wr(int a, logic [DW-1:0] d); step(1, a, d, 0, 0, 0, ""); endtask
  task automatic rd(int a, string tag);       step(0, 0, '0, 1, a, 0, tag); endtask
  task automatic idle();                      step(0, 0, '0, 0, 0, 0, ""); endtask
  task automatic done();                      step(0, 0, '0, 0, 0, 1, ""); endtask

  task automatic program_layer(int l);
    for (int k = 0; k < NREG; k++) wr(k, pat(l, k));
  endtask

  initial begin
    #(100000 * 10);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    m_prod = 0; m_cons = 0; m_busy = 0; m_err = 0; m_after_done = 0;
    m_en = 0; m_sts = 0; m_mask = 0;
    for (int g = 0; g < 2; g++) for (int k = 0; k < NREG; k++) m_cfg[g][k] = '0;
    rst_n = 1'b0; wr_en = 0; wr_addr = 0; wr_data = 0;
    rd_en = 0; rd_addr = 0; eng_done = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    chk("R1", NREG*DW'(eng_start), '0);
    chk("R1", NREG*DW'(irq), '0);
    rd(NREG + 1, "R1");
    chk("R1", NREG*DW'(rd_data), '0);
    rd(NREG + 2, "R1");
    rd(NREG + 3, "R1");

    for (int l = 0; l < 16; l++) begin
      bit queued;
      queued = (l % 3 == 1);
      program_layer(2 * l);
      rd(l % NREG, "R2");
      if (l % 4 == 2) wr(NREG + 3, 32'h3);          // R9: mask both flags
      wr(NREG, 32'h1);                               // R3/R4 activate
      rd(NREG + 1, "R3");
      if (queued) begin
        program_layer(2 * l + 1);
        rd((l + 1) % NREG, "R2");
        wr(NREG, 32'h1);                             // R6 queue second layer
        rd(NREG + 1, "R3");
        wr(l % NREG, 32'hDEAD_BEEF);                 // R7 blocked write
        rd(l % NREG, "R7");
        wr(NREG, 32'h1);                             // R7 blocked activate
        rd(NREG + 1, "R7");
        wr(NREG + 1, 32'h10);                        // R7 clear error
        rd(NREG + 1, "R7");
      end
      for (int c = 0; c < l % 4; c++) idle();
      done();                                        // R5
      rd(NREG + 1, "R5");
      rd(NREG + 2, "R5");
      if (queued) begin
        idle();
        done();
        rd(NREG + 1, "R5");
      end
      if (l % 4 == 2) begin
        rd(NREG + 3, "R9");
        wr(NREG + 3, 32'h1);                         // R9 unmask group 1 only
        wr(NREG + 3, 32'h0);
      end
      wr(NREG + 2, 32'h0);                           // R8: zero leaves flags
      rd(NREG + 2, "R8");
      wr(NREG + 2, DW'(1 + (l % 2)));                // R8: clear one flag
      rd(NREG + 2, "R8");
      wr(NREG + 2, 32'h3);
      rd(NREG + 2, "R8");
    end

    // R10: completion while idle
    done();
    rd(NREG + 1, "R10");
    rd(NREG + 2, "R10");
    chk("R10", NREG*DW'(irq), '0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule